// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache placed between a processor's single-word load/store port and a memory port that moves whole lines. Every access carries a 32-bit byte address. The address is split into four fields. From the top bit down they are a 16-bit tag, an 11-bit set index, a 3-bit word select and a 2-bit byte offset. The set index picks one of 2048 entries. Each entry holds a valid flag, a dirty flag, a stored tag and one 32-byte line of eight 32-bit words, so the cache holds 64 KB of data.

A read that finds its line returns the selected word without touching memory. A write that finds its line changes only the selected word and marks the line dirty. On a miss the controller first checks the line it is about to replace. If that line is dirty, it streams it back to memory as eight word beats. It then fetches the new line as eight word beats, installs it and finishes the original access. A write miss therefore allocates the line first and then writes into it. The processor sees a stall flag for as long as an access is in progress, and the cache accepts nothing new until the current access is done.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every entry is invalid, `cpu_stall_o`, `cpu_done_o` and `mem_valid_o` are low, and the first access to any address is a miss.
- R2: Address bits [31:16] are the tag, [15:5] the set index, [4:2] the word within the line, and [1:0] the byte offset, which has no effect on which word is read or written.
- R3: An access hits only when the indexed entry is valid and its stored tag equals the address tag. A different tag on the same set index misses.
- R4: A read hit returns the addressed word with `cpu_done_o` high during the second cycle after the request is accepted, and it raises no memory beat.
- R5: A miss on a clean or invalid entry fetches eight read beats (`mem_we_o` low) at byte addresses line base + 4k, k = 0..7 in increasing order. The new line then replaces the entry and the access completes with the fetched data.
- R6: A miss on a dirty entry first sends eight write beats (`mem_we_o` high) holding the old line, at the old tag's line base + 4k in increasing order, and only then starts the refill beats.
- R7: A write hit replaces only the addressed word, marks the line dirty and raises no memory beat.
- R8: A write miss refills the line, then writes the word and marks the line dirty. A later read of that word hits and returns the written value.
- R9: `cpu_stall_o` is high from the cycle after a request is accepted until the cycle after `cpu_done_o`. A request presented while the stall is high is ignored, and `cpu_done_o` is a single-cycle pulse per access.
- R10: A memory beat completes only on a clock edge where `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, `mem_addr_o` and `mem_we_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_req_i | input | 1 | Access request, sampled while the cache is not stalled |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address of the access |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid while `cpu_done_o` is high |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_stall_o | output | 1 | High while an access is being serviced |
| mem_valid_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr_o | output | 32 | Byte address of the current beat |
| mem_wdata_o | output | 32 | Write-back beat data |
| mem_ready_i | input | 1 | Memory accepts or delivers the current beat |
| mem_rdata_i | input | 32 | Refill beat data, valid with `mem_ready_i` |

## Verification
The embedded assertions watch, on every cycle, that a lookup hit starts no memory beat and that a dirty miss opens with a write beat. They also check that a stalled beat keeps its address and direction, that a completed refill leaves the entry valid, that a store leaves it dirty, and that the completion flag never lasts two cycles. Only the bench scenarios can show that the data is right end to end. They check the returned words, that written-back beats carry the stored words to the old address, the ordering and count of beats, that the byte offset is ignored, and that a request made during a stall never takes effect.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOOKUP  = 3'd1,
    ST_WBACK   = 3'd2,
    ST_REFILL  = 3'd3,
    ST_RESPOND = 3'd4
  } cstate_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] idx_i,
  input  logic              fill_we_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              dirty_we_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int LINES = 1 << LINE_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // flags: cleared by reset, set by fill / store
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_we_i) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= 1'b0;
      end
      if (dirty_we_i) begin
        dirty_q[idx_i] <= 1'b1;
      end
    end
  end

  // tag array: written only on line install
  always_ff @(posedge clk_i) begin
    if (fill_we_i) begin
      tag_mem[idx_i] <= fill_tag_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_mem[idx_i];

  // R5: an installed line is valid afterwards
  a_r5_fill_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_n)
    fill_we_i |=> valid_q[$past(idx_i)]);

  // R7: a store leaves its line dirty
  a_r7_store_sets_dirty: assert property (@(posedge clk_i) disable iff (!rst_n)
    dirty_we_i |=> dirty_q[$past(idx_i)]);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int DATA_W = 32,
  parameter int LINE_W = 11,
  parameter int WORD_W = 3
) (
  input  logic              clk_i,
  input  logic [LINE_W-1:0] idx_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LINES = 1 << LINE_W;
  localparam int WORDS = 1 << WORD_W;

  logic [WORDS-1:0][DATA_W-1:0] line_mem [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      line_mem[idx_i][word_i] <= wdata_i;
    end
  end

  assign rdata_o = line_mem[idx_i][word_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 11,
  parameter int WORD_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                done_o,
  output logic                stall_o,
  output logic                mem_valid_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_ready_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [LINE_W-1:0]   idx_o,
  input  logic                st_valid_i,
  input  logic                st_dirty_i,
  input  logic [ADDR_W-LINE_W-WORD_W-$clog2(DATA_W/8)-1:0] st_tag_i,
  output logic                fill_we_o,
  output logic [ADDR_W-LINE_W-WORD_W-$clog2(DATA_W/8)-1:0] fill_tag_o,
  output logic                dirty_we_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                data_we_o,
  output logic [DATA_W-1:0]   data_wdata_o,
  input  logic [DATA_W-1:0]   data_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int TAG_W  = ADDR_W - LINE_W - WORD_W - BYTE_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = '1;
  localparam logic [WORD_W-1:0] ONE_BEAT  = {{(WORD_W-1){1'b0}}, 1'b1};
  localparam logic [BYTE_W-1:0] NO_BYTE   = '0;

  cstate_t             state_q, state_d;
  logic [WORD_W-1:0]   beat_q, beat_d;
  logic                beat_en;
  logic                cap_en;
  logic [TAG_W-1:0]    atag_q;
  logic [LINE_W-1:0]   line_q;
  logic [WORD_W-1:0]   word_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                hit;
  logic                victim_dirty;
  logic                unused_byte;

  assign unused_byte  = ^addr_i[BYTE_W-1:0];
  assign hit          = st_valid_i && (st_tag_i == atag_q);
  assign victim_dirty = st_valid_i && st_dirty_i;

  // next-state and output decode
  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    beat_en      = 1'b0;
    cap_en       = 1'b0;
    data_we_o    = 1'b0;
    data_wdata_o = wdata_q;
    fill_we_o    = 1'b0;
    dirty_we_o   = 1'b0;
    mem_valid_o  = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = {atag_q, line_q, beat_q, NO_BYTE};
    done_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          cap_en  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        beat_en = 1'b1;
        beat_d  = '0;
        if (hit)               state_d = ST_RESPOND;
        else if (victim_dirty) state_d = ST_WBACK;
        else                   state_d = ST_REFILL;
      end
      ST_WBACK: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {st_tag_i, line_q, beat_q, NO_BYTE};
        if (mem_ready_i) begin
          beat_en = 1'b1;
          beat_d  = beat_q + ONE_BEAT;
          if (beat_q == LAST_BEAT) state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_valid_o = 1'b1;
        if (mem_ready_i) begin
          data_we_o    = 1'b1;
          data_wdata_o = mem_rdata_i;
          beat_en      = 1'b1;
          beat_d       = beat_q + ONE_BEAT;
          if (beat_q == LAST_BEAT) begin
            fill_we_o = 1'b1;
            state_d   = ST_RESPOND;
          end
        end
      end
      ST_RESPOND: begin
        done_o = 1'b1;
        if (we_q) begin
          data_we_o  = 1'b1;
          dirty_we_o = 1'b1;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  // request capture, enabled only while idle
  always_ff @(posedge clk_i) begin
    if (cap_en) begin
      atag_q  <= addr_i[ADDR_W-1 -: TAG_W];
      line_q  <= addr_i[BYTE_W+WORD_W +: LINE_W];
      word_q  <= addr_i[BYTE_W +: WORD_W];
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  assign idx_o       = line_q;
  assign fill_tag_o  = atag_q;
  assign word_o      = (state_q == ST_WBACK || state_q == ST_REFILL) ? beat_q : word_q;
  assign mem_wdata_o = data_rdata_i;
  assign stall_o     = (state_q != ST_IDLE);
  assign rdata_o     = (done_o && !we_q) ? data_rdata_i : '0;

  // R4: a lookup hit raises no memory beat
  a_r4_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_LOOKUP && hit) |=> !mem_valid_o);

  // R6: a dirty miss opens with a write-back beat
  a_r6_dirty_miss_writes_first: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_LOOKUP && !hit && victim_dirty) |=> (mem_valid_o && mem_we_o));

  // R10: a stalled beat holds address and direction
  a_r10_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 11,
  parameter int WORD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic              cpu_stall_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int TAG_W  = ADDR_W - LINE_W - WORD_W - BYTE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [LINE_W-1:0] idx;
  logic              st_valid, st_dirty;
  logic [TAG_W-1:0]  st_tag, fill_tag;
  logic              fill_we, dirty_we;
  logic [WORD_W-1:0] word_sel;
  logic              data_we;
  logic [DATA_W-1:0] data_wdata, data_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .addr_i       (cpu_addr_i),
    .wdata_i      (cpu_wdata_i),
    .rdata_o      (cpu_rdata_o),
    .done_o       (cpu_done_o),
    .stall_o      (cpu_stall_o),
    .mem_valid_o  (mem_valid_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rdata_i  (mem_rdata_i),
    .idx_o        (idx),
    .st_valid_i   (st_valid),
    .st_dirty_i   (st_dirty),
    .st_tag_i     (st_tag),
    .fill_we_o    (fill_we),
    .fill_tag_o   (fill_tag),
    .dirty_we_o   (dirty_we),
    .word_o       (word_sel),
    .data_we_o    (data_we),
    .data_wdata_o (data_wdata),
    .data_rdata_i (data_rdata)
  );

  cache_tag_store #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_tags (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .idx_i      (idx),
    .fill_we_i  (fill_we),
    .fill_tag_i (fill_tag),
    .dirty_we_i (dirty_we),
    .valid_o    (st_valid),
    .dirty_o    (st_dirty),
    .tag_o      (st_tag)
  );

  cache_data_store #(.DATA_W(DATA_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk_i   (clk_i),
    .idx_i   (idx),
    .word_i  (word_sel),
    .we_i    (data_we),
    .wdata_i (data_wdata),
    .rdata_o (data_rdata)
  );
endmodule

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cpu_req_i, cpu_we_i;
  logic [31:0] cpu_addr_i, cpu_wdata_i, cpu_rdata_o;
  logic        cpu_done_o, cpu_stall_o;
  logic        mem_valid_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  int checks = 0;
  int errors = 0;

  // memory model and beat log
  logic [31:0] mem_arr [int unsigned];
  logic [31:0] log_a [32];
  logic [31:0] log_d [32];
  bit          log_w [32];
  int          nb = 0;
  bit          slow = 1'b0;

  always #5 clk_i = ~clk_i;

  dm_wb_cache u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .cpu_done_o(cpu_done_o),
    .cpu_stall_o(cpu_stall_o), .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] dflt(input logic [29:0] wa);
    return {wa[15:0], wa[29:14]} ^ 32'h5A3C_00A5;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    int unsigned k = int'(a >> 2);
    return mem_arr.exists(k) ? mem_arr[k] : dflt(a[31:2]);
  endfunction

  // R2 field order: tag[31:16] line[15:5] word[4:2] byte[1:0]
  function automatic logic [31:0] mk(input int tag, input int line, input int word);
    return {tag[15:0], line[10:0], word[2:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder, works at falling edges
  initial begin
    bit          tog = 1'b0;
    bit          prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    bit          rdy;
    mem_ready_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      if (prev_wait)
        chk(mem_addr_o == prev_addr, "R10 address held while not ready", mem_addr_o, prev_addr);
      rdy = slow ? tog : 1'b1;
      tog = !tog;
      mem_ready_i = rdy;
      if (mem_valid_o && rdy) begin
        if (nb < 32) begin
          log_a[nb] = mem_addr_o;
          log_w[nb] = mem_we_o;
          log_d[nb] = mem_wdata_o;
        end
        nb++;
        if (mem_we_o) mem_arr[int'(mem_addr_o >> 2)] = mem_wdata_o;
        else          mem_rdata_i = mem_rd(mem_addr_o);
      end
      prev_wait = mem_valid_o && !rdy;
      prev_addr = mem_addr_o;
    end
  end

  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    bit stall_ok = 1'b1;
    @(negedge clk_i);
    nb = 0;
    cpu_req_i = 1'b1; cpu_we_i = w; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    lat = 1;
    while (!cpu_done_o) begin
      if (!cpu_stall_o) stall_ok = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    rd = cpu_rdata_o;
    chk(stall_ok && cpu_stall_o, "R9 stall high until done", {31'd0, stall_ok}, 32'd1);
  endtask

  // beats [first, first+8) must be direction w at base + 4k
  task automatic chk_beats(input int first, input bit w, input logic [31:0] base, input string req);
    bit ok = 1'b1;
    logic [31:0] bad_a = '0;
    for (int k = 0; k < 8; k++) begin
      if (log_a[first+k] != base + 32'(4*k) || log_w[first+k] != w) begin
        ok = 1'b0; bad_a = log_a[first+k];
      end
    end
    chk(ok, req, bad_a, base);
  endtask

  task automatic t_reset();
    chk(!cpu_stall_o && !cpu_done_o && !mem_valid_o, "R1 idle outputs after reset",
        {29'd0, cpu_stall_o, cpu_done_o, mem_valid_o}, 32'd0);
  endtask

  task automatic t_read_miss_clean();
    logic [31:0] rd; int lat;
    access(1'b0, mk(1, 5, 3), '0, rd, lat);
    chk(nb == 8, "R1 first access misses with 8 beats", nb, 8);
    chk_beats(0, 1'b0, mk(1, 5, 0), "R5 refill beat order");
    chk(rd == dflt(mk(1, 5, 3) >> 2), "R5 refill returns fetched word", rd, dflt(mk(1, 5, 3) >> 2));
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int lat;
    access(1'b0, mk(1, 5, 6), '0, rd, lat);
    chk(nb == 0, "R4 read hit no memory beat", nb, 0);
    chk(lat == 2, "R4 read hit latency", lat, 2);
    chk(rd == dflt(mk(1, 5, 6) >> 2), "R4 read hit data", rd, dflt(mk(1, 5, 6) >> 2));
  endtask

  task automatic t_byte_ignored();
    logic [31:0] rd; int lat;
    access(1'b0, mk(1, 5, 6) | 32'd3, '0, rd, lat);
    chk(nb == 0 && rd == dflt(mk(1, 5, 6) >> 2), "R2 byte offset ignored", rd, dflt(mk(1, 5, 6) >> 2));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int lat;
    access(1'b1, mk(1, 5, 2), 32'hCAFE_0001, rd, lat);
    chk(nb == 0, "R7 write hit no memory beat", nb, 0);
    access(1'b0, mk(1, 5, 2), '0, rd, lat);
    chk(rd == 32'hCAFE_0001 && nb == 0, "R7 written word read back", rd, 32'hCAFE_0001);
    access(1'b0, mk(1, 5, 1), '0, rd, lat);
    chk(rd == dflt(mk(1, 5, 1) >> 2), "R7 neighbour word untouched", rd, dflt(mk(1, 5, 1) >> 2));
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int lat;
    bit ok = 1'b1;
    access(1'b0, mk(2, 5, 4), '0, rd, lat);
    chk(nb == 16, "R3 tag mismatch misses, R6 total beats", nb, 16);
    chk_beats(0, 1'b1, mk(1, 5, 0), "R6 write-back beats first at old address");
    chk_beats(8, 1'b0, mk(2, 5, 0), "R6 refill beats after write-back");
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e = (k == 2) ? 32'hCAFE_0001 : dflt(mk(1, 5, k) >> 2);
      if (log_d[k] != e) ok = 1'b0;
    end
    chk(ok, "R6 write-back carries stored line", log_d[2], 32'hCAFE_0001);
    chk(rd == dflt(mk(2, 5, 4) >> 2), "R6 new line data", rd, dflt(mk(2, 5, 4) >> 2));
    // clean victim now: only refill, and memory holds the written word
    access(1'b0, mk(1, 5, 2), '0, rd, lat);
    chk(nb == 8, "R5 clean victim needs only refill", nb, 8);
    chk(rd == 32'hCAFE_0001, "R6 written-back word returns from memory", rd, 32'hCAFE_0001);
  endtask

  task automatic t_write_miss_slow();
    logic [31:0] rd; int lat;
    slow = 1'b1;
    access(1'b1, mk(3, 9, 7), 32'hBEEF_0042, rd, lat);
    chk(nb == 8, "R8 write miss refills first (R10 slow ready)", nb, 8);
    chk_beats(0, 1'b0, mk(3, 9, 0), "R10 beats complete in order under slow ready");
    slow = 1'b0;
    access(1'b0, mk(3, 9, 7), '0, rd, lat);
    chk(rd == 32'hBEEF_0042 && nb == 0, "R8 allocated word holds write", rd, 32'hBEEF_0042);
    access(1'b0, mk(4, 9, 0), '0, rd, lat);
    chk(nb == 16 && log_w[0] && log_d[7] == 32'hBEEF_0042, "R8 write miss left line dirty",
        log_d[7], 32'hBEEF_0042);
  endtask

  task automatic t_busy_ignored();
    logic [31:0] rd; int lat;
    bit quiet = 1'b1;
    @(negedge clk_i);
    nb = 0;
    cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = mk(5, 20, 0);
    @(negedge clk_i);
    cpu_we_i = 1'b1; cpu_addr_i = mk(6, 21, 1); cpu_wdata_i = 32'h1111_2222;
    while (!cpu_done_o) @(negedge clk_i);
    cpu_req_i = 1'b0;
    chk(nb == 8, "R9 only first request serviced", nb, 8);
    nb = 0;
    repeat (4) begin
      @(negedge clk_i);
      if (cpu_stall_o || mem_valid_o) quiet = 1'b0;
    end
    chk(quiet && nb == 0, "R9 request during stall not taken", nb, 0);
    access(1'b0, mk(6, 21, 1), '0, rd, lat);
    chk(nb == 8 && rd == dflt(mk(6, 21, 1) >> 2), "R9 ignored store never written",
        rd, dflt(mk(6, 21, 1) >> 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0; cpu_addr_i = '0; cpu_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_read_miss_clean();
    t_read_hit();
    t_byte_ignored();
    t_write_hit();
    t_dirty_evict();
    t_write_miss_slow();
    t_busy_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule